// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. It counts on a one-cycle count-enable tick rather than on its own clock. A gate input starts, restarts or suspends counting, and a single OUT line carries the result. Software sets the counting mode and the byte-access pattern with a configuration write. The initial count then arrives as one or two byte writes. The live count and the OUT level can be read at any time.

The channel supports six modes:

- Mode 0: expiry flag.
- Mode 1: gate-retriggered one-shot.
- Mode 2: rate generator.
- Mode 3: square wave.
- Mode 4: software-started strobe.
- Mode 5: gate-started strobe.

Mode codes 6 and 7 fold onto modes 2 and 3. A written count of zero stands for the full range of 65536.

The control logic has two state machines:

- **Byte loader.** It has two states, `LS_LOW` and `LS_HIGH`. In two-byte access, the first count write moves it from `LS_LOW` to `LS_HIGH`. The second write returns it to `LS_LOW` and issues the load. A configuration write forces it back to `LS_LOW`.
- **Counting core.** It has three states, `CS_IDLE`, `CS_COUNT` and `CS_WRAPPED`.
  - A configuration write sends any state to `CS_IDLE`.
  - A completed count load leaves `CS_IDLE` for `CS_COUNT`.
  - In modes 0, 1, 4 and 5, the first expiry moves `CS_COUNT` to `CS_WRAPPED`.
  - A reload, a retrigger or a new load returns `CS_WRAPPED` to `CS_COUNT`.

Top module: `pict_channel`

## Requirements
- R1: After reset the count reads 0, OUT is low and the channel is idle. After any accepted configuration write, the channel ignores ticks and keeps OUT low until a complete initial count has been written.
- R2: The access field of a configuration write selects the count format:
  - 01: a single byte gives the low half, and the high half is 0.
  - 10: a single byte gives the high half, and the low half is 0.
  - 11: the low byte is written first, then the high byte.
  - 00: the whole configuration write is ignored, and mode and counting carry on unchanged.
- R3: A written initial count of 0 acts as 65536. One tick after such a load, the count reads 0xFFFF.
- R4: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R5: Mode 0 decrements once per tick while the gate is high. OUT is low from the load until the count reaches 0, and high after that. The count keeps decrementing and wraps past 0 to 0xFFFF.
- R6: Mode 1 starts a one-shot on load. OUT is low until the count reaches 0, then high. A rising gate edge restarts the one-shot from the initial count with OUT low.
- R7: Mode 2 reloads the initial count after N ticks and runs periodically. OUT is high for exactly the tick interval that follows each reload, and low at load time.
- R8: Mode 3 steps the count down by 2 per tick, modulo N. OUT is high for the first ceil(N/2) ticks of each N-tick period, and high right after load.
- R9: Modes 4 and 5 raise OUT for exactly one tick interval when the count first reaches 0. The count then wraps to 0xFFFF and keeps going. Mode 4 is held while the gate is low.
- R10: In modes 0 and 4 the gate level only enables or suspends decrementing, and a rising edge does not restart. In modes 1, 2, 3 and 5 the gate level has no effect, and a rising edge restarts counting from the initial count.
- R11: In modes 2 and 3, a count written while running takes effect at the next reload and does not disturb the current period.
- R12: The count and OUT change only on a tick, a count load, a gate restart or a configuration write. A new count in modes 0, 1, 4 and 5 restarts at once. A load appears two clocks after its final byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable tick, one clock wide |
| gate_i | input | 1 | Gate input |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Counting mode code, 0 to 7 |
| cfg_acc_i | input | 2 | Count access format |
| cnt_we_i | input | 1 | Count byte write strobe |
| cnt_byte_i | input | 8 | Count byte |
| count_o | output | 16 | Live count |
| out_o | output | 1 | OUT level |

## Verification
The bench aims at three edge cases:

- **Boundaries.** It checks the full-range zero count, wrap past zero in the one-shot and strobe modes, and the odd-count square wave. Getting the half-period rounding wrong would show up as OUT falling one tick early. Getting the wrap wrong would freeze the count at 0.
- **Deferred loads.** It writes a new count in the middle of a rate-generator period. A design that applied the count at once would show the new value before the boundary.
- **Gate handling.** It makes a gate rising edge follow a low period in every gate-sensitive mode. A design that confused level and edge handling would restart mode 0 or stall mode 1.

A half-written two-byte count, and a configuration write with access 00, must both leave the channel visibly unchanged.

// File: rtl/pict_pkg.sv
package pict_pkg;

    typedef enum logic [2:0] {
        M_EXPIRE   = 3'd0,
        M_RETRIG   = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pict_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } pict_acc_e;

    typedef enum logic {
        LS_LOW  = 1'b0,
        LS_HIGH = 1'b1
    } pict_ld_state_e;

    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_COUNT   = 2'd1,
        CS_WRAPPED = 2'd2
    } pict_core_state_e;

    // Codes 6 and 7 fold onto the periodic modes 2 and 3.
    function automatic pict_mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) begin
            return pict_mode_e'({1'b0, code[1:0]});
        end
        return pict_mode_e'(code);
    endfunction

endpackage

// File: rtl/pict_loader.sv
module pict_loader
    import pict_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_mode,
    input  logic [1:0]    cfg_acc,
    input  logic          cnt_we,
    input  logic [CW/2-1:0] cnt_byte,
    output pict_mode_e    mode,
    output logic          cfg_pulse,
    output logic          ld_pulse,
    output logic [CW-1:0] ld_val
);
    localparam int BW = CW / 2;

    pict_ld_state_e ls_q, ls_d;
    pict_acc_e      acc_q;
    pict_mode_e     mode_q;
    logic [BW-1:0]  low_q;
    logic           cfg_pulse_q, ld_pulse_q;
    logic [CW-1:0]  ld_val_q;
    logic           cfg_take;

    assign cfg_take = cfg_we && (cfg_acc != ACC_NONE);

    // Byte-phase state machine
    always_comb begin
        ls_d = ls_q;
        if (cfg_take) begin
            ls_d = LS_LOW;
        end else if (cnt_we && acc_q == ACC_WORD) begin
            unique case (ls_q)
                LS_LOW:  ls_d = LS_HIGH;
                LS_HIGH: ls_d = LS_LOW;
                default: ls_d = LS_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ls_q <= LS_LOW;
        else        ls_q <= ls_d;
    end

    // Configuration and load outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= ACC_WORD;
            mode_q      <= M_EXPIRE;
            low_q       <= '0;
            cfg_pulse_q <= 1'b0;
            ld_pulse_q  <= 1'b0;
            ld_val_q    <= '0;
        end else begin
            cfg_pulse_q <= 1'b0;
            ld_pulse_q  <= 1'b0;
            if (cfg_take) begin
                mode_q      <= fold_mode(cfg_mode);
                acc_q       <= pict_acc_e'(cfg_acc);
                cfg_pulse_q <= 1'b1;
            end else if (cnt_we) begin
                unique case (acc_q)
                    ACC_LO: begin
                        ld_val_q   <= {{BW{1'b0}}, cnt_byte};
                        ld_pulse_q <= 1'b1;
                    end
                    ACC_HI: begin
                        ld_val_q   <= {cnt_byte, {BW{1'b0}}};
                        ld_pulse_q <= 1'b1;
                    end
                    default: begin
                        if (ls_q == LS_LOW) begin
                            low_q <= cnt_byte;
                        end else begin
                            ld_val_q   <= {cnt_byte, low_q};
                            ld_pulse_q <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign mode      = mode_q;
    assign cfg_pulse = cfg_pulse_q;
    assign ld_pulse  = ld_pulse_q;
    assign ld_val    = ld_val_q;

    AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse_q |-> $past(cnt_we)); // R2
    AST_IGNORED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_acc == ACC_NONE && !cnt_we) |=> ($stable(mode_q) && !cfg_pulse_q)); // R2

endmodule

// File: rtl/pict_core.sv
module pict_core
    import pict_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gate,
    input  pict_mode_e    mode,
    input  logic          cfg_pulse,
    input  logic          ld_pulse,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] count,
    output logic          out
);
    localparam int NW = CW + 1;
    localparam logic [NW-1:0] FULL = {1'b1, {CW{1'b0}}};

    pict_core_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, pos_q, pos_d;
    logic [NW-1:0] act_q, act_d, pend_q, pend_d;
    logic          pend_v_q, pend_v_d, out_q, out_d, gate_q;

    logic          periodic, level_gated, gate_rise, edge_restart, start_now, step;
    logic [NW-1:0] ld_n, nxt_n, e_cur, sq_next, half;

    assign periodic     = (mode == M_RATE) || (mode == M_SQUARE);
    assign level_gated  = (mode == M_EXPIRE) || (mode == M_SWSTROBE);
    assign gate_rise    = gate && !gate_q;
    assign edge_restart = (st_q != CS_IDLE) && gate_rise && !level_gated;
    assign start_now    = (ld_pulse && (st_q == CS_IDLE || !periodic)) || edge_restart;
    assign step         = tick && (st_q != CS_IDLE) && (!level_gated || gate);
    assign ld_n         = (ld_val == '0) ? FULL : {1'b0, ld_val};
    assign nxt_n        = ld_pulse ? ld_n : (pend_v_q ? pend_q : act_q);
    assign e_cur        = (cnt_q == '0) ? FULL : {1'b0, cnt_q};
    assign sq_next      = (e_cur > NW'(2)) ? (e_cur - NW'(2)) : (e_cur + act_q - NW'(2));
    assign half         = (act_q + NW'(1)) >> 1;

    // Next-state and datapath
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        act_d    = act_q;
        pend_d   = pend_q;
        pend_v_d = pend_v_q;
        pos_d    = pos_q;
        out_d    = out_q;
        if (cfg_pulse) begin
            st_d     = CS_IDLE;
            out_d    = 1'b0;
            pend_v_d = 1'b0;
        end else if (start_now) begin
            st_d     = CS_COUNT;
            act_d    = nxt_n;
            cnt_d    = nxt_n[CW-1:0];
            pos_d    = '0;
            out_d    = (mode == M_SQUARE);
            pend_v_d = 1'b0;
        end else begin
            if (ld_pulse) begin
                pend_d   = ld_n;
                pend_v_d = 1'b1;
            end
            if (step) begin
                unique case (mode)
                    M_RATE: begin
                        if (cnt_q == CW'(1)) begin
                            cnt_d    = nxt_n[CW-1:0];
                            act_d    = nxt_n;
                            pend_v_d = 1'b0;
                            out_d    = 1'b1;
                        end else begin
                            cnt_d = cnt_q - CW'(1);
                            out_d = 1'b0;
                        end
                    end
                    M_SQUARE: begin
                        if ({1'b0, pos_q} == act_q - NW'(1)) begin
                            cnt_d    = nxt_n[CW-1:0];
                            act_d    = nxt_n;
                            pend_v_d = 1'b0;
                            pos_d    = '0;
                            out_d    = 1'b1;
                        end else begin
                            cnt_d = sq_next[CW-1:0];
                            pos_d = pos_q + CW'(1);
                            out_d = (({1'b0, pos_q} + NW'(1)) < half);
                        end
                    end
                    M_EXPIRE, M_RETRIG: begin
                        cnt_d = cnt_q - CW'(1);
                        if (cnt_q == CW'(1)) begin
                            st_d  = CS_WRAPPED;
                            out_d = 1'b1;
                        end
                    end
                    M_SWSTROBE, M_HWSTROBE: begin
                        cnt_d = cnt_q - CW'(1);
                        out_d = (cnt_q == CW'(1)) && (st_q == CS_COUNT);
                        if (cnt_q == CW'(1)) st_d = CS_WRAPPED;
                    end
                    default: ;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_q    <= FULL;
            pend_q   <= FULL;
            pend_v_q <= 1'b0;
            pos_q    <= '0;
            out_q    <= 1'b0;
            gate_q   <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            act_q    <= act_d;
            pend_q   <= pend_d;
            pend_v_q <= pend_v_d;
            pos_q    <= pos_d;
            out_q    <= out_d;
            gate_q   <= gate;
        end
    end

    assign count = cnt_q;
    assign out   = out_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_IDLE) |-> !out_q); // R1
    AST_ACT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CS_IDLE) |-> (act_q != '0)); // R3
    AST_SQUARE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CS_IDLE && mode == M_SQUARE) |-> ({1'b0, pos_q} < act_q)); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_SWSTROBE || mode == M_HWSTROBE) && out_q && step
         && !ld_pulse && !cfg_pulse && !gate_rise) |=> !out_q); // R9
    AST_GATE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (level_gated && !gate && !ld_pulse && !cfg_pulse) |=> $stable(cnt_q)); // R10
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CS_IDLE && !tick && !ld_pulse && !cfg_pulse && !gate_rise)
        |=> ($stable(cnt_q) && $stable(out_q))); // R12

endmodule

// File: rtl/pict_channel.sv
module pict_channel
    import pict_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          gate_i,
    input  logic          cfg_we_i,
    input  logic [2:0]    cfg_mode_i,
    input  logic [1:0]    cfg_acc_i,
    input  logic          cnt_we_i,
    input  logic [CW/2-1:0] cnt_byte_i,
    output logic [CW-1:0] count_o,
    output logic          out_o
);
    pict_mode_e    mode;
    logic          cfg_pulse, ld_pulse;
    logic [CW-1:0] ld_val;

    pict_loader #(.CW(CW)) i_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we_i),
        .cfg_mode  (cfg_mode_i),
        .cfg_acc   (cfg_acc_i),
        .cnt_we    (cnt_we_i),
        .cnt_byte  (cnt_byte_i),
        .mode      (mode),
        .cfg_pulse (cfg_pulse),
        .ld_pulse  (ld_pulse),
        .ld_val    (ld_val)
    );

    pict_core #(.CW(CW)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .gate      (gate_i),
        .mode      (mode),
        .cfg_pulse (cfg_pulse),
        .ld_pulse  (ld_pulse),
        .ld_val    (ld_val),
        .count     (count_o),
        .out       (out_o)
    );

endmodule

// File: tb/test_pict_channel.sv
`timescale 1ns/1ps
module test_pict_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        gate_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_mode_i = '0;
    logic [1:0]  cfg_acc_i = '0;
    logic        cnt_we_i = 1'b0;
    logic [7:0]  cnt_byte_i = '0;
    logic [15:0] count_o;
    logic        out_o;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    pict_channel i_pict_channel (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
        .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i), .cfg_acc_i(cfg_acc_i),
        .cnt_we_i(cnt_we_i), .cnt_byte_i(cnt_byte_i),
        .count_o(count_o), .out_o(out_o)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic [15:0] n;
        logic [7:0]  nt;
        logic [15:0] ec;
        logic        eo;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 16'd5, 8'd3, 16'h0002, 1'b0, 4'd5},  // R5 mid count
        '{3'd0, 16'd5, 8'd5, 16'h0000, 1'b1, 4'd5},  // R5 reached zero
        '{3'd0, 16'd5, 8'd7, 16'hFFFE, 1'b1, 4'd5},  // R5 wrap
        '{3'd0, 16'd0, 8'd1, 16'hFFFF, 1'b0, 4'd3},  // R3 full range
        '{3'd1, 16'd4, 8'd2, 16'h0002, 1'b0, 4'd6},  // R6 running low
        '{3'd1, 16'd4, 8'd4, 16'h0000, 1'b1, 4'd6},  // R6 expired high
        '{3'd2, 16'd3, 8'd2, 16'h0001, 1'b0, 4'd7},  // R7
        '{3'd2, 16'd3, 8'd3, 16'h0003, 1'b1, 4'd7},  // R7 reload pulse
        '{3'd2, 16'd3, 8'd4, 16'h0002, 1'b0, 4'd7},  // R7 pulse ends
        '{3'd2, 16'd3, 8'd0, 16'h0003, 1'b0, 4'd7},  // R7 no pulse at load
        '{3'd3, 16'd6, 8'd2, 16'h0002, 1'b1, 4'd8},  // R8 even
        '{3'd3, 16'd6, 8'd3, 16'h0006, 1'b0, 4'd8},  // R8 even half
        '{3'd3, 16'd5, 8'd2, 16'h0001, 1'b1, 4'd8},  // R8 odd, rounded up
        '{3'd3, 16'd5, 8'd3, 16'h0004, 1'b0, 4'd8},  // R8 odd low half
        '{3'd3, 16'd5, 8'd5, 16'h0005, 1'b1, 4'd8},  // R8 period boundary
        '{3'd4, 16'd3, 8'd2, 16'h0001, 1'b0, 4'd9},  // R9
        '{3'd4, 16'd3, 8'd3, 16'h0000, 1'b1, 4'd9},  // R9 strobe
        '{3'd4, 16'd3, 8'd4, 16'hFFFF, 1'b0, 4'd9},  // R9 strobe ends, wrap
        '{3'd5, 16'd2, 8'd2, 16'h0000, 1'b1, 4'd9},  // R9 mode 5 strobe
        '{3'd6, 16'd2, 8'd2, 16'h0002, 1'b1, 4'd4},  // R4 code 6 as rate
        '{3'd7, 16'd4, 8'd2, 16'h0004, 1'b0, 4'd4}   // R4 code 7 as square
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] md, input logic [1:0] acc);
        cfg_mode_i = md; cfg_acc_i = acc; cfg_we_i = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0;
        cyc(2);
    endtask

    task automatic wr(input logic [7:0] b);
        cnt_byte_i = b; cnt_we_i = 1'b1;
        @(negedge clk);
        cnt_we_i = 1'b0;
    endtask

    task automatic load_word(input logic [15:0] n);
        wr(n[7:0]);
        wr(n[15:8]);
        cyc(3);
    endtask

    task automatic tk(input int n);
        for (int k = 0; k < n; k++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk(input int rq, input logic [15:0] ec, input logic eo);
        nchk++;
        if (count_o !== ec || out_o !== eo) begin
            nfail++;
            $display("FAIL R%0d: count=%h out=%b expected count=%h out=%b",
                     rq, count_o, out_o, ec, eo);
        end
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog: count=%h out=%b expected completion", count_o, out_o);
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(1, 16'h0000, 1'b0);                  // R1 reset state

        // R1: half-written word keeps the channel idle
        cfg(3'd0, 2'd3);
        wr(8'h04);
        tk(3);
        chk(1, 16'h0000, 1'b0);                  // R1
        wr(8'h00);
        cyc(3);
        chk(1, 16'h0004, 1'b0);                  // R1 load completes

        // Vector table
        for (int i = 0; i < NV; i++) begin
            cfg(VEC[i].md, 2'd3);
            load_word(VEC[i].n);
            tk(int'(VEC[i].nt));
            chk(int'(VEC[i].rq), VEC[i].ec, VEC[i].eo);
        end

        // R2 access formats and ignored config
        cfg(3'd0, 2'd1);
        wr(8'h07); cyc(3);
        chk(2, 16'h0007, 1'b0);                  // R2 low only
        cfg(3'd0, 2'd2);
        wr(8'h02); cyc(3);
        chk(2, 16'h0200, 1'b0);                  // R2 high only
        cfg(3'd2, 2'd0);
        tk(1);
        chk(2, 16'h01FF, 1'b0);                  // R2 access 00 ignored

        // R10 gate level in mode 0, no restart on edge
        cfg(3'd0, 2'd3);
        load_word(16'd10);
        tk(2);
        gate_i = 1'b0; cyc(2);
        tk(3);
        chk(10, 16'd8, 1'b0);                    // R10 suspended
        gate_i = 1'b1; cyc(2);
        chk(10, 16'd8, 1'b0);                    // R10 no restart
        tk(1);
        chk(5, 16'd7, 1'b0);                     // R5 resumes

        // R6 retrigger in mode 1; gate level ignored
        cfg(3'd1, 2'd3);
        load_word(16'd4);
        tk(2);
        gate_i = 1'b0; cyc(2);
        tk(1);
        chk(10, 16'd1, 1'b0);                    // R10 level ignored
        gate_i = 1'b1; cyc(2);
        chk(6, 16'd4, 1'b0);                     // R6 restart
        tk(4);
        chk(6, 16'd0, 1'b1);                     // R6 expired

        // R11 deferred count in mode 2
        cfg(3'd2, 2'd3);
        load_word(16'd3);
        tk(1);
        load_word(16'd5);
        chk(11, 16'd2, 1'b0);                    // R11 not yet
        tk(1);
        chk(11, 16'd1, 1'b0);                    // R11
        tk(1);
        chk(11, 16'd5, 1'b1);                    // R11 new count at reload
        tk(1);
        chk(11, 16'd4, 1'b0);                    // R11

        // R10 gate restart in mode 3
        cfg(3'd3, 2'd3);
        load_word(16'd6);
        tk(4);
        chk(8, 16'd4, 1'b0);                     // R8 second half
        gate_i = 1'b0; cyc(2);
        gate_i = 1'b1; cyc(2);
        chk(10, 16'd6, 1'b1);                    // R10 restart

        // R9 mode 4 held by gate
        cfg(3'd4, 2'd3);
        load_word(16'd2);
        gate_i = 1'b0; cyc(1);
        tk(2);
        chk(9, 16'd2, 1'b0);                     // R9 held
        gate_i = 1'b1; cyc(2);
        tk(2);
        chk(9, 16'd0, 1'b1);                     // R9 strobe
        tk(1);
        chk(9, 16'hFFFF, 1'b0);                  // R9 single tick

        // R10 mode 5 restart
        cfg(3'd5, 2'd3);
        load_word(16'd3);
        tk(3);
        gate_i = 1'b0; cyc(2);
        gate_i = 1'b1; cyc(2);
        chk(10, 16'd3, 1'b0);                    // R10 mode 5 restart

        // R3 zero in periodic mode
        cfg(3'd2, 2'd3);
        load_word(16'd0);
        tk(1);
        chk(3, 16'hFFFF, 1'b0);                  // R3

        // R12 rewrite in mode 0 restarts at once
        cfg(3'd0, 2'd3);
        load_word(16'd9);
        tk(2);
        load_word(16'd3);
        chk(12, 16'd3, 1'b0);                    // R12
        cyc(4);
        chk(12, 16'd3, 1'b0);                    // R12 holds without tick

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule